// File: doc/BRIEF.md
# Subvector Byte Pack/Unpack Mover

This block moves elements inside a small register array. One side of the move is grouped into subvectors of SUBVL narrow elements (2 to 4). The other side holds plain wide elements of one register each. In pack mode, every group of narrow source elements is merged into one wide destination register, one narrow element per byte lane. In unpack mode, every wide source register is split back into a group of narrow destination elements. Narrow elements are 8 or 16 bits wide. A wide element always carries 8-bit lanes, so 16-bit narrow elements are narrowed on packing and widened on unpacking.

A move starts with a one-cycle `start` pulse while the block is idle. The configuration, predicate and base registers are captured at that edge. The block then handles one wide element per clock, from index 0 up to VL-1, and pulses `done` when it has finished. The register array can be written and read through a host port, and host writes are blocked while a move is running. A predicate bit per wide element lets any element be skipped. Optional saturation clamps each narrowed lane in signed or unsigned mode.

Top module: `smv_mover`

## Requirements
- R1: Narrow element k lives in the byte view of the array, where byte b is bits [8(b%4)+7:8(b%4)] of register b/4. An 8-bit element k is byte (base*4 + k). A 16-bit element k has its low byte at (base*4 + 2k) and its high byte at (base*4 + 2k + 1). In pack mode (`unpack`=0), byte j of register dst+i, for j < SUBVL, holds the converted narrow source element i*SUBVL+j.
- R2: In pack mode, every byte lane j >= SUBVL of a written destination register is written as zero (byte 3 for SUBVL=3, bytes 2 and 3 for SUBVL=2).
- R3: In unpack mode (`unpack`=1), narrow destination element i*SUBVL+j receives bits [8j+7:8j] of register src+i, for j < SUBVL. No other byte of the array changes.
- R4: When predicate bit i is 0, element i writes nothing and its destination keeps its old contents. Other elements are still moved.
- R5: In pack mode with 16-bit narrow elements and saturation off, each lane takes the low 8 bits of its element.
- R6: In pack mode with 16-bit narrow elements and saturation on, unsigned mode (`sat_signed`=0) clamps each lane to 0..255. Signed mode clamps the two's-complement value to -128..127, giving 0x80 below and 0x7F above.
- R7: In unpack mode with 16-bit narrow elements, each lane byte is zero-extended, except when saturation is on in signed mode, where it is sign-extended.
- R8: After the start edge, element i is written at the (i+1)-th rising edge. `busy` is high for exactly VL cycles, and `done` is a one-cycle pulse in the cycle after the last element. With VL=0, `done` pulses in the cycle right after the start edge, `busy` stays low and nothing is written.
- R9: A `start` pulse while busy is ignored, and so is a host write while busy.
- R10: After reset, `busy` and `done` are 0 and every register of the array reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (taken only when idle) |
| unpack | input | 1 | 0 = pack narrow groups into wide, 1 = unpack wide into groups |
| vl | input | 4 | Number of wide elements (0..MAXVL) |
| subvl | input | 3 | Group size, 2 to 4 |
| narrow16 | input | 1 | Narrow element width: 0 = 8 bits, 1 = 16 bits |
| sat_en | input | 1 | Saturation enable |
| sat_signed | input | 1 | Saturation mode: 1 = signed, 0 = unsigned |
| pred | input | 8 | Predicate, bit i enables wide element i |
| src_reg | input | 4 | Source base register |
| dst_reg | input | 4 | Destination base register |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host write strobe (ignored while busy) |
| host_waddr | input | 4 | Host write register index |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 4 | Host read register index |
| host_rdata | output | 32 | Host read data (combinational) |

## Verification
The bench targets the grouping boundaries. With SUBVL of 3 and 2, a design that leaves stale upper lanes or computes group starts with the wrong stride produces the wrong destination bytes. For unpack moves whose last group ends in the middle of a register, the bench verifies that the untouched bytes of that register survive, so a full-register write shows up as corruption. Saturation is tested with values just outside and just inside both ranges, plus 0xFFFF and 0x8000, which catch a clamp done on the wrong sign. Sign versus zero extension is tested with lane bytes that have bit 7 set. A cycle-by-cycle run checks that elements land one edge apart, that `done` comes one cycle after the last element, and that VL=0 finishes at once. Mid-run start and host-write pulses check that a move cannot be hijacked.

// File: rtl/smv_pkg.sv
`timescale 1ns/1ps
package smv_pkg;

  typedef enum logic {MV_PACK = 1'b0, MV_UNPACK = 1'b1} mv_mode_e;

  typedef struct packed {
    mv_mode_e mode;
    logic     nar16;
    logic     sat_en;
    logic     sat_sgn;
  } mv_flags_t;

  // narrow element (8 or 16 bits, zero-padded) to one 8-bit lane
  function automatic logic [7:0] narrow_to_lane(input logic [15:0] v, input logic is16,
                                                input logic sat, input logic sgn);
    logic [7:0] r;
    r = v[7:0];
    if (is16 && sat) begin
      if (sgn) begin
        if (!v[15] && (v[14:7] != 8'h00)) r = 8'h7F;
        else if (v[15] && (v[14:7] != 8'hFF)) r = 8'h80;
      end else if (v[15:8] != 8'h00) begin
        r = 8'hFF;
      end
    end
    return r;
  endfunction

  // 8-bit lane widened to a 16-bit narrow element
  function automatic logic [15:0] lane_to_narrow(input logic [7:0] b, input logic sat,
                                                 input logic sgn);
    return (sat && sgn) ? {{8{b[7]}}, b} : {8'h00, b};
  endfunction

endpackage

// File: rtl/smv_regfile.sv
`timescale 1ns/1ps
module smv_regfile #(
  parameter int NREG = 16,
  parameter int BPR  = 4,
  parameter int NP   = 8,
  parameter int RAW  = 4,
  parameter int ABW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [RAW-1:0]          host_waddr,
  input  logic [8*BPR-1:0]        host_wdata,
  input  logic [RAW-1:0]          host_raddr,
  output logic [8*BPR-1:0]        host_rdata,
  input  logic [NP-1:0]           mv_we,
  input  logic [NP-1:0][ABW-1:0]  mv_baddr,
  input  logic [NP-1:0][7:0]      mv_bdata,
  input  logic [NP-1:0][ABW-1:0]  rd_baddr,
  output logic [NP-1:0][7:0]      rd_bdata
);
  localparam int NB = NREG * BPR;

  logic [7:0] mem [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) mem[b] <= 8'h00;
    end else begin
      if (host_we) begin
        for (int b = 0; b < BPR; b++)
          mem[int'(host_waddr) * BPR + b] <= host_wdata[8*b +: 8];
      end
      for (int p = 0; p < NP; p++) begin
        if (mv_we[p]) mem[mv_baddr[p]] <= mv_bdata[p];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BPR; b++)
      host_rdata[8*b +: 8] = mem[int'(host_raddr) * BPR + b];
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_bdata[p] = mem[rd_baddr[p]];
  end

endmodule

// File: rtl/smv_ctrl.sv
`timescale 1ns/1ps
module smv_ctrl
  import smv_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int RAW   = 4,
  parameter int SVW   = 3,
  parameter int IW    = $clog2(MAXVL),
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mv_flags_t        flags_in,
  input  logic [VLW-1:0]   vl_in,
  input  logic [SVW-1:0]   subvl_in,
  input  logic [MAXVL-1:0] pred_in,
  input  logic [RAW-1:0]   src_in,
  input  logic [RAW-1:0]   dst_in,
  output logic             busy,
  output logic             done,
  output logic [IW-1:0]    idx,
  output logic             fire,
  output logic             last_elem,
  output mv_flags_t        flags_q,
  output logic [SVW-1:0]   subvl_q,
  output logic [RAW-1:0]   src_q,
  output logic [RAW-1:0]   dst_q
);
  logic [VLW-1:0]   vl_q, vl_eff;
  logic [MAXVL-1:0] pred_q;

  assign vl_eff    = (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;
  assign last_elem = busy && ((VLW'(idx) + VLW'(1)) == vl_q);
  assign fire      = busy && pred_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      vl_q    <= '0;
      pred_q  <= '0;
      flags_q <= '0;
      subvl_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          flags_q <= flags_in;
          subvl_q <= subvl_in;
          pred_q  <= pred_in;
          src_q   <= src_in;
          dst_q   <= dst_in;
          vl_q    <= vl_eff;
          idx     <= '0;
          if (vl_eff == '0) done <= 1'b1;
          else              busy <= 1'b1;
        end
      end else if (last_elem) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  // R8: completion follows the last element by one cycle
  a_r8_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    last_elem |=> (done && !busy));
  // R8: done lasts one cycle only
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: empty move finishes at once
  a_r8_zero_vl: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (vl_in == '0)) |=> (done && !busy));
  // R9: a start during a move leaves the captured setup alone
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(flags_q) && $stable(src_q) && $stable(dst_q) && $stable(subvl_q)));

endmodule

// File: rtl/smv_lanes.sv
`timescale 1ns/1ps
module smv_lanes
  import smv_pkg::*;
#(
  parameter int BPR = 4,
  parameter int ABW = 6,
  parameter int RAW = 4,
  parameter int IW  = 3,
  parameter int SVW = 3,
  parameter int NP  = 2 * BPR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  mv_flags_t              flags,
  input  logic [SVW-1:0]         subvl,
  input  logic [IW-1:0]          idx,
  input  logic [RAW-1:0]         src_reg,
  input  logic [RAW-1:0]         dst_reg,
  input  logic                   fire,
  output logic [NP-1:0][ABW-1:0] rd_baddr,
  input  logic [NP-1:0][7:0]     rd_bdata,
  output logic [NP-1:0]          wr_en,
  output logic [NP-1:0][ABW-1:0] wr_baddr,
  output logic [NP-1:0][7:0]     wr_bdata
);
  logic [ABW-1:0] src_base, dst_base, grp_base, wide_off;

  assign src_base = ABW'(src_reg) * ABW'(BPR);
  assign dst_base = ABW'(dst_reg) * ABW'(BPR);
  assign grp_base = ABW'(idx) * ABW'(subvl);
  assign wide_off = ABW'(idx) * ABW'(BPR);

  logic [BPR-1:0][ABW-1:0] kidx;     // narrow element index per lane
  logic [BPR-1:0]          lane_on;  // lane inside the group
  logic [BPR-1:0][15:0]    nv;       // narrow value read in pack mode
  logic [BPR-1:0][7:0]     pk;       // packed lane byte
  logic [BPR-1:0][15:0]    un;       // widened value in unpack mode

  for (genvar l = 0; l < BPR; l++) begin : g_lane
    assign kidx[l]    = grp_base + ABW'(l);
    assign lane_on[l] = SVW'(l) < subvl;
    assign nv[l]      = flags.nar16 ? {rd_bdata[2*l+1], rd_bdata[2*l]} : {8'h00, rd_bdata[2*l]};
    assign pk[l]      = lane_on[l] ? narrow_to_lane(nv[l], flags.nar16, flags.sat_en, flags.sat_sgn)
                                   : 8'h00;
    assign un[l]      = lane_to_narrow(rd_bdata[l], flags.sat_en, flags.sat_sgn);

    // R2: lanes past the group are cleared in pack mode
    a_r2_spare_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && flags.mode == MV_PACK && !lane_on[l]) |-> (wr_en[l] && wr_bdata[l] == 8'h00));
    // R6: signed clamp keeps the sign of the wide value
    a_r6_signed_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && flags.mode == MV_PACK && flags.nar16 && flags.sat_en && flags.sat_sgn && lane_on[l])
        |-> (wr_bdata[l][7] == nv[l][15]));
    // R6: unsigned overflow pins the lane at its top value
    a_r6_unsigned_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && flags.mode == MV_PACK && flags.nar16 && flags.sat_en && !flags.sat_sgn
        && lane_on[l] && (nv[l][15:8] != 8'h00)) |-> (wr_bdata[l] == 8'hFF));
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      if (flags.mode == MV_PACK) begin
        rd_baddr[p] = flags.nar16 ? (src_base + (kidx[p/2] << 1) + ABW'(p % 2))
                                  : (src_base + kidx[p/2]);
        wr_en[p]    = fire && (p < BPR);
        wr_baddr[p] = dst_base + wide_off + ABW'(p % BPR);
        wr_bdata[p] = pk[p % BPR];
      end else begin
        rd_baddr[p] = src_base + wide_off + ABW'(p % BPR);
        if (flags.nar16) begin
          wr_en[p]    = fire && lane_on[p/2];
          wr_baddr[p] = dst_base + (kidx[p/2] << 1) + ABW'(p % 2);
          wr_bdata[p] = (p % 2 == 1) ? un[p/2][15:8] : un[p/2][7:0];
        end else begin
          wr_en[p]    = fire && (p < BPR) && lane_on[p % BPR];
          wr_baddr[p] = dst_base + kidx[p % BPR];
          wr_bdata[p] = un[p % BPR][7:0];
        end
      end
    end
  end

endmodule

// File: rtl/smv_mover.sv
`timescale 1ns/1ps
module smv_mover
  import smv_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int REGW  = 32,
  parameter int MAXVL = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         unpack,
  input  logic [$clog2(MAXVL+1)-1:0]   vl,
  input  logic [$clog2(REGW/8+1)-1:0]  subvl,
  input  logic                         narrow16,
  input  logic                         sat_en,
  input  logic                         sat_signed,
  input  logic [MAXVL-1:0]             pred,
  input  logic [$clog2(NREG)-1:0]      src_reg,
  input  logic [$clog2(NREG)-1:0]      dst_reg,
  output logic                         busy,
  output logic                         done,
  input  logic                         host_we,
  input  logic [$clog2(NREG)-1:0]      host_waddr,
  input  logic [REGW-1:0]              host_wdata,
  input  logic [$clog2(NREG)-1:0]      host_raddr,
  output logic [REGW-1:0]              host_rdata
);
  localparam int BPR = REGW / 8;
  localparam int NP  = 2 * BPR;
  localparam int RAW = $clog2(NREG);
  localparam int ABW = $clog2(NREG * BPR);
  localparam int IW  = $clog2(MAXVL);
  localparam int VLW = $clog2(MAXVL + 1);
  localparam int SVW = $clog2(BPR + 1);

  mv_flags_t      flags_in, flags_q;
  logic [SVW-1:0] subvl_q;
  logic [RAW-1:0] src_q, dst_q;
  logic [IW-1:0]  idx;
  logic           fire, last_elem, rf_host_we;

  logic [NP-1:0][ABW-1:0] rd_baddr, mv_baddr;
  logic [NP-1:0][7:0]     rd_bdata, mv_bdata;
  logic [NP-1:0]          mv_we;

  assign flags_in   = '{mode: mv_mode_e'(unpack), nar16: narrow16, sat_en: sat_en, sat_sgn: sat_signed};
  assign rf_host_we = host_we && !busy;

  smv_ctrl #(.MAXVL(MAXVL), .RAW(RAW), .SVW(SVW), .IW(IW), .VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .flags_in(flags_in), .vl_in(vl),
    .subvl_in(subvl), .pred_in(pred), .src_in(src_reg), .dst_in(dst_reg),
    .busy(busy), .done(done), .idx(idx), .fire(fire), .last_elem(last_elem),
    .flags_q(flags_q), .subvl_q(subvl_q), .src_q(src_q), .dst_q(dst_q)
  );

  smv_lanes #(.BPR(BPR), .ABW(ABW), .RAW(RAW), .IW(IW), .SVW(SVW), .NP(NP)) u_lanes (
    .clk(clk), .rst_n(rst_n), .flags(flags_q), .subvl(subvl_q), .idx(idx),
    .src_reg(src_q), .dst_reg(dst_q), .fire(fire),
    .rd_baddr(rd_baddr), .rd_bdata(rd_bdata),
    .wr_en(mv_we), .wr_baddr(mv_baddr), .wr_bdata(mv_bdata)
  );

  smv_regfile #(.NREG(NREG), .BPR(BPR), .NP(NP), .RAW(RAW), .ABW(ABW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .host_we(rf_host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .mv_we(mv_we), .mv_baddr(mv_baddr), .mv_bdata(mv_bdata),
    .rd_baddr(rd_baddr), .rd_bdata(rd_bdata)
  );

  // R4: a masked element writes no byte
  a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |-> (mv_we == '0));
  // R8: nothing is written while idle
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mv_we == '0));
  // R9: host writes never reach the array during a move
  a_r9_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rf_host_we);
  // R8: the final element is followed by the done pulse
  a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/test_smv_mover.sv
`timescale 1ns/1ps
module test_smv_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, unpack = 1'b0, narrow16 = 1'b0, sat_en = 1'b0, sat_signed = 1'b0;
  logic [3:0]  vl = '0;
  logic [2:0]  subvl = 3'd4;
  logic [7:0]  pred = '0;
  logic [3:0]  src_reg = '0, dst_reg = '0, host_waddr = '0, host_raddr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        busy, done;
  logic [31:0] host_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] m [16];
  logic [31:0] snap [16];

  always #10 clk = ~clk;  // 50 MHz

  smv_mover i_smv_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .unpack(unpack), .vl(vl), .subvl(subvl),
    .narrow16(narrow16), .sat_en(sat_en), .sat_signed(sat_signed), .pred(pred),
    .src_reg(src_reg), .dst_reg(dst_reg), .busy(busy), .done(done),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gb(input int a);
    return m[(a / 4) % 16][8 * (a % 4) +: 8];
  endfunction

  task automatic sb(input int a, input logic [7:0] v);
    m[(a / 4) % 16][8 * (a % 4) +: 8] = v;
  endtask

  function automatic logic [7:0] to_lane(input logic [15:0] v, input bit n16, input bit sat, input bit sgn);
    int s;
    if (!n16 || !sat) return v[7:0];
    if (sgn) begin
      s = $signed(v);
      if (s > 127)  return 8'h7F;
      if (s < -128) return 8'h80;
      return v[7:0];
    end
    if (v > 16'd255) return 8'hFF;
    return v[7:0];
  endfunction

  task automatic model(input bit up, input int n, input int sv, input bit n16, input bit sat,
                       input bit sgn, input logic [7:0] pm, input int s, input int d);
    for (int i = 0; i < n; i++) begin
      if (pm[i]) begin
        if (!up) begin
          logic [31:0] w;
          w = 32'h0;
          for (int j = 0; j < sv; j++) begin
            int k;
            logic [15:0] v;
            k = i * sv + j;
            v = n16 ? {gb(s*4 + 2*k + 1), gb(s*4 + 2*k)} : {8'h00, gb(s*4 + k)};
            w[8*j +: 8] = to_lane(v, n16, sat, sgn);
          end
          m[(d + i) % 16] = w;
        end else begin
          logic [31:0] w;
          w = m[(s + i) % 16];
          for (int j = 0; j < sv; j++) begin
            int k;
            logic [7:0] bt;
            k = i * sv + j;
            bt = w[8*j +: 8];
            if (n16) begin
              sb(d*4 + 2*k, bt);
              sb(d*4 + 2*k + 1, (sat && sgn && bt[7]) ? 8'hFF : 8'h00);
            end else begin
              sb(d*4 + k, bt);
            end
          end
        end
      end
    end
  endtask

  task automatic hwrite(input int r, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 4'(r); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    m[r] = v;
  endtask

  task automatic fill(input int seed);
    for (int r = 0; r < 16; r++)
      hwrite(r, (32'h9E3779B9 * (r + seed + 1)) ^ (r * 32'h01010101));
  endtask

  function automatic logic [31:0] rd(input int r);
    return 32'h0;
  endfunction

  task automatic peek(input int r, output logic [31:0] v);
    host_raddr = 4'(r);
    #1;
    v = host_rdata;
  endtask

  task automatic compare_all(input string req);
    for (int r = 0; r < 16; r++) begin
      logic [31:0] v;
      peek(r, v);
      check(v === m[r], req, $sformatf("reg %0d", r), v, m[r]);
    end
  endtask

  task automatic set_cfg(input bit up, input int n, input int sv, input bit n16, input bit sat,
                         input bit sgn, input logic [7:0] pm, input int s, input int d);
    unpack = up; vl = 4'(n); subvl = 3'(sv); narrow16 = n16; sat_en = sat; sat_signed = sgn;
    pred = pm; src_reg = 4'(s); dst_reg = 4'(d);
  endtask

  task automatic run_move(input string req, input bit up, input int n, input int sv, input bit n16,
                          input bit sat, input bit sgn, input logic [7:0] pm, input int s, input int d);
    int cnt;
    @(negedge clk);
    set_cfg(up, n, sv, n16, sat, sgn, pm, s, d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(done === 1'b1, req, "done seen", 32'(done), 32'h1);
    model(up, n, sv, n16, sat, sgn, pm, s, d);
    compare_all(req);
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R10", "busy after reset", 32'(busy), 32'h0);
    check(done === 1'b0, "R10", "done after reset", 32'(done), 32'h0);
    for (int r = 0; r < 16; r++) m[r] = 32'h0;
    compare_all("R10");
  endtask

  task automatic t_pack_bytes();
    fill(3);
    run_move("R1", 1'b0, 4, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 8);
  endtask

  task automatic t_pack_short();
    fill(7);
    run_move("R2", 1'b0, 3, 3, 1'b0, 1'b0, 1'b0, 8'hFF, 1, 10);
    run_move("R2", 1'b0, 2, 2, 1'b0, 1'b0, 1'b0, 8'hFF, 2, 13);
  endtask

  task automatic load_sat_vals();
    hwrite(0, 32'h0123_007F);
    hwrite(1, 32'hFF7F_FF80);
    hwrite(2, 32'h8000_7FFF);
    hwrite(3, 32'hFFFF_0080);
  endtask

  task automatic t_pack_trunc();
    fill(11);
    load_sat_vals();
    run_move("R5", 1'b0, 2, 4, 1'b1, 1'b0, 1'b0, 8'hFF, 0, 8);
    check(m[8] === 32'h7F80_237F, "R5", "literal truncation", m[8], 32'h7F80_237F);
  endtask

  task automatic t_pack_sat();
    logic [31:0] v;
    fill(13);
    load_sat_vals();
    run_move("R6", 1'b0, 2, 4, 1'b1, 1'b1, 1'b0, 8'hFF, 0, 8);
    peek(8, v);  check(v === 32'hFFFF_FF7F, "R6", "unsigned lanes elem0", v, 32'hFFFF_FF7F);
    peek(9, v);  check(v === 32'hFF80_FFFF, "R6", "unsigned lanes elem1", v, 32'hFF80_FFFF);
    run_move("R6", 1'b0, 2, 4, 1'b1, 1'b1, 1'b1, 8'hFF, 0, 12);
    peek(12, v); check(v === 32'h8080_7F7F, "R6", "signed lanes elem0", v, 32'h8080_7F7F);
    peek(13, v); check(v === 32'hFF7F_807F, "R6", "signed lanes elem1", v, 32'hFF7F_807F);
  endtask

  task automatic t_unpack_bytes();
    fill(17);
    run_move("R3", 1'b1, 2, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 4, 0);
    run_move("R3", 1'b1, 3, 3, 1'b0, 1'b0, 1'b0, 8'hFF, 4, 8);
  endtask

  task automatic t_unpack_wide();
    logic [31:0] v;
    fill(19);
    hwrite(6, 32'h00FF_7F80);
    run_move("R7", 1'b1, 3, 2, 1'b1, 1'b0, 1'b0, 8'hFF, 6, 0);
    peek(0, v); check(v === 32'h007F_0080, "R7", "zero extension", v, 32'h007F_0080);
    run_move("R7", 1'b1, 3, 2, 1'b1, 1'b1, 1'b1, 8'hFF, 6, 8);
    peek(8, v); check(v === 32'h007F_FF80, "R7", "sign extension", v, 32'h007F_FF80);
    run_move("R7", 1'b1, 2, 3, 1'b1, 1'b1, 1'b0, 8'hFF, 6, 12);
  endtask

  task automatic t_pred();
    fill(23);
    run_move("R4", 1'b0, 4, 4, 1'b0, 1'b0, 1'b0, 8'b0000_0101, 0, 8);
    run_move("R4", 1'b1, 2, 4, 1'b0, 1'b0, 1'b0, 8'b0000_0010, 12, 0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    fill(29);
    snap = m;
    @(negedge clk);
    set_cfg(1'b0, 3, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 8);
    start = 1'b1;
    @(negedge clk);  // after start edge
    start = 1'b0;
    model(1'b0, 3, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 8);
    check(busy === 1'b1, "R8", "busy after start", 32'(busy), 32'h1);
    peek(8, v); check(v === snap[8], "R8", "elem0 not yet", v, snap[8]);
    @(negedge clk);  // after edge 1
    check(busy === 1'b1, "R8", "busy cycle 2", 32'(busy), 32'h1);
    peek(8, v); check(v === m[8], "R8", "elem0 written", v, m[8]);
    peek(9, v); check(v === snap[9], "R8", "elem1 not yet", v, snap[9]);
    @(negedge clk);  // after edge 2
    check(busy === 1'b1 && done === 1'b0, "R8", "busy cycle 3", {busy, done}, 32'h2);
    peek(9, v); check(v === m[9], "R8", "elem1 written", v, m[9]);
    @(negedge clk);  // after edge 3
    check(busy === 1'b0 && done === 1'b1, "R8", "done pulse", {busy, done}, 32'h1);
    @(negedge clk);
    check(done === 1'b0, "R8", "done one cycle", 32'(done), 32'h0);
    compare_all("R8");
    @(negedge clk);
    set_cfg(1'b0, 0, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0 && done === 1'b1, "R8", "empty move done", {busy, done}, 32'h1);
    @(negedge clk);
    check(done === 1'b0, "R8", "empty move pulse", 32'(done), 32'h0);
    compare_all("R8");
  endtask

  task automatic t_ignore();
    int cnt;
    fill(31);
    @(negedge clk);
    set_cfg(1'b0, 4, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 8);
    start = 1'b1;
    @(negedge clk);
    set_cfg(1'b1, 2, 2, 1'b1, 1'b1, 1'b1, 8'hFF, 8, 0);
    host_we = 1'b1; host_waddr = 4'd15; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    start = 1'b0; host_we = 1'b0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(done === 1'b1, "R9", "first move done", 32'(done), 32'h1);
    model(1'b0, 4, 4, 1'b0, 1'b0, 1'b0, 8'hFF, 0, 8);
    compare_all("R9");
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R9", "no second move", {busy, done}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack_bytes();
    t_pack_short();
    t_pack_trunc();
    t_pack_sat();
    t_unpack_bytes();
    t_unpack_wide();
    t_pred();
    t_timing();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule